// File: doc/BRIEF.md
# Multi-channel ADC threshold watchdog

This block watches converted ADC results and reports any that fall outside a programmed window. A pool of sixteen low/high threshold pairs is shared by all channels. Each channel has a selector naming the pair that applies to it and a bit in an enable mask. A result enters on a valid/ready stream together with its channel index. The block compares it, unsigned, against the selected pair. A result outside the window marks the channel in a sticky out-of-range vector and raises a sticky low-side or high-side flag on the pair that was violated.

Configuration arrives over a single-cycle register write port. Software clears status by writing ones to the bits it wants cleared. The stream side never applies back-pressure: `res_ready` rises on the first clock after reset and stays high, so one result can be accepted every cycle. A result is taken on any rising edge where both `res_valid` and `res_ready` are high. Once taken, it cannot be withdrawn.

If a pair is programmed with its high bound below its low bound, the outcome is still fixed. A result below the low bound raises only the low flag. Any other result raises only the high flag.

Top module: `adc_limit_monitor`

## Requirements
- R1: While `rst_n` is low, `oor_status`, `low_flag`, `high_flag`, the enable mask and `res_ready` are all zero. Every selector resets to pair 0. Every pair resets to low = 0 and high = 4095.
- R2: A write to address 0x00+k (k = 0..15) loads pair k, taking the low bound from data[11:0] and the high bound from data[27:16]. One pair may be selected by any number of channels.
- R3: A write to address 0x10+c loads channel c's selector from data[3:0]. That selector applies to every later result on channel c until it is rewritten.
- R4: A write to address 0x20 loads the enable mask from data[NUM_CH-1:0]. A result on a channel whose enable bit is 0 leaves `oor_status`, `low_flag` and `high_flag` unchanged.
- R5: A result on an enabled channel with low <= result <= high changes no status bit.
- R6: On an enabled channel with a well-ordered pair p, a result below low sets `oor_status[c]` and `low_flag[p]`. A result above high sets `oor_status[c]` and `high_flag[p]`.
- R7: When high < low, a result below low sets only `low_flag[p]`. A result equal to or above low sets only `high_flag[p]`. In both cases `oor_status[c]` is set. At most one flag is newly set per result.
- R8: Writing to address 0x21, 0x22 or 0x23 clears the bits of `oor_status`, `low_flag` or `high_flag` where data is 1. Other bits are kept. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: `res_ready` is high in every cycle after the first clock out of reset. A result taken at edge N updates the status outputs at edge N+1. Results on consecutive cycles are all processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result present |
| res_ready | output | 1 | Block can accept a result |
| res_chan | input | $clog2(NUM_CH) | Channel index of the result |
| res_data | input | 12 | Unsigned conversion result |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| oor_status | output | NUM_CH | Sticky per-channel out-of-range bits |
| low_flag | output | NUM_PAIRS | Sticky per-pair low-violation flags |
| high_flag | output | NUM_PAIRS | Sticky per-pair high-violation flags |

## Verification
The properties assume that any change to the status outputs comes from either a result being compared or a register write in the previous cycle. They also assume that `res_chan` is always below NUM_CH. Both hold for the default of eight channels with a 3-bit index.

The bench drives every input on the falling clock edge. It changes pair, selector or enable settings only while no result is in flight between acceptance and comparison. Because of this, each expected value depends only on the settings that were in force when the result was sent.

// File: rtl/adc_wd_pkg.sv
package adc_wd_pkg;
  localparam int RES_W  = 12;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int HI_LSB = 16;

  localparam logic [ADDR_W-1:0] A_PAIR_BASE = 6'h00;
  localparam logic [ADDR_W-1:0] A_SEL_BASE  = 6'h10;
  localparam logic [ADDR_W-1:0] A_EN        = 6'h20;
  localparam logic [ADDR_W-1:0] A_CLR_OOR   = 6'h21;
  localparam logic [ADDR_W-1:0] A_CLR_LO    = 6'h22;
  localparam logic [ADDR_W-1:0] A_CLR_HI    = 6'h23;

  typedef struct packed {
    logic [RES_W-1:0] hi;
    logic [RES_W-1:0] lo;
  } wd_pair_t;
endpackage

// File: rtl/adc_wd_cfg.sv
module adc_wd_cfg
  import adc_wd_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_PAIRS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output wd_pair_t                     pair_q [NUM_PAIRS],
  output logic [$clog2(NUM_PAIRS)-1:0] sel_q  [NUM_CH],
  output logic [NUM_CH-1:0]            en_q
);
  localparam int SEL_W = $clog2(NUM_PAIRS);

  logic unused_data;
  assign unused_data = ^wr_data;

  // shared threshold pool
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pair_q[k].lo <= '0;
        pair_q[k].hi <= '1;
      end else if (wr_en && wr_addr == A_PAIR_BASE + ADDR_W'(k)) begin
        pair_q[k].lo <= wr_data[RES_W-1:0];
        pair_q[k].hi <= wr_data[HI_LSB +: RES_W];
      end
    end
  end

  // per-channel pair selectors
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[c] <= '0;
      end else if (wr_en && wr_addr == A_SEL_BASE + ADDR_W'(c)) begin
        sel_q[c] <= wr_data[SEL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en && wr_addr == A_EN) begin
      en_q <= wr_data[NUM_CH-1:0];
    end
  end
endmodule

// File: rtl/adc_wd_cmp.sv
module adc_wd_cmp
  import adc_wd_pkg::*;
(
  input  wd_pair_t         pair,
  input  logic [RES_W-1:0] result,
  output logic             below,
  output logic             above
);
  // the low test is decided first, so an inverted pair yields exactly one side
  always_comb begin
    below = result < pair.lo;
    above = !below && (result > pair.hi);
  end
endmodule

// File: rtl/adc_wd_flags.sv
module adc_wd_flags
  import adc_wd_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_PAIRS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd,
  input  logic [$clog2(NUM_CH)-1:0]    chan,
  input  logic [$clog2(NUM_PAIRS)-1:0] pair_idx,
  input  logic                         below,
  input  logic                         above,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NUM_CH-1:0]            oor_q,
  output logic [NUM_PAIRS-1:0]         lo_q,
  output logic [NUM_PAIRS-1:0]         hi_q
);
  logic [NUM_CH-1:0]    set_oor, clr_oor;
  logic [NUM_PAIRS-1:0] set_lo, set_hi, clr_lo, clr_hi;
  logic                 unused_data;

  assign unused_data = ^wr_data;

  always_comb begin
    set_oor = (upd && (below || above)) ? (NUM_CH'(1) << chan) : '0;
    set_lo  = (upd && below) ? (NUM_PAIRS'(1) << pair_idx) : '0;
    set_hi  = (upd && above) ? (NUM_PAIRS'(1) << pair_idx) : '0;
    clr_oor = (wr_en && wr_addr == A_CLR_OOR) ? wr_data[NUM_CH-1:0]    : '0;
    clr_lo  = (wr_en && wr_addr == A_CLR_LO)  ? wr_data[NUM_PAIRS-1:0] : '0;
    clr_hi  = (wr_en && wr_addr == A_CLR_HI)  ? wr_data[NUM_PAIRS-1:0] : '0;
  end

  // set takes priority over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oor_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      oor_q <= (oor_q & ~clr_oor) | set_oor;
      lo_q  <= (lo_q  & ~clr_lo)  | set_lo;
      hi_q  <= (hi_q  & ~clr_hi)  | set_hi;
    end
  end
endmodule

// File: rtl/adc_limit_monitor.sv
module adc_limit_monitor
  import adc_wd_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_PAIRS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      res_valid,
  output logic                      res_ready,
  input  logic [$clog2(NUM_CH)-1:0] res_chan,
  input  logic [RES_W-1:0]          res_data,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [NUM_CH-1:0]         oor_status,
  output logic [NUM_PAIRS-1:0]      low_flag,
  output logic [NUM_PAIRS-1:0]      high_flag
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int SEL_W = $clog2(NUM_PAIRS);

  logic             ready_q;
  logic             s1_valid;
  logic [CH_W-1:0]  s1_chan;
  logic [RES_W-1:0] s1_res;
  logic             s1_en;
  logic             below, above;

  wd_pair_t         pair_q [NUM_PAIRS];
  logic [SEL_W-1:0] sel_q  [NUM_CH];
  logic [NUM_CH-1:0] en_q;
  logic [SEL_W-1:0] act_sel;
  wd_pair_t         act_pair;

  assign res_ready = ready_q;

  // capture stage: one result per cycle, no back-pressure
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      s1_valid <= 1'b0;
      s1_chan  <= '0;
      s1_res   <= '0;
    end else begin
      ready_q  <= 1'b1;
      s1_valid <= res_valid && ready_q;
      if (res_valid && ready_q) begin
        s1_chan <= res_chan;
        s1_res  <= res_data;
      end
    end
  end

  adc_wd_cfg #(.NUM_CH(NUM_CH), .NUM_PAIRS(NUM_PAIRS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pair_q(pair_q), .sel_q(sel_q), .en_q(en_q)
  );

  assign act_sel  = sel_q[s1_chan];
  assign act_pair = pair_q[act_sel];
  assign s1_en    = s1_valid && en_q[s1_chan];

  adc_wd_cmp u_cmp (
    .pair(act_pair), .result(s1_res), .below(below), .above(above)
  );

  adc_wd_flags #(.NUM_CH(NUM_CH), .NUM_PAIRS(NUM_PAIRS)) u_flags (
    .clk(clk), .rst_n(rst_n), .upd(s1_en), .chan(s1_chan),
    .pair_idx(act_sel), .below(below), .above(above),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .oor_q(oor_status), .lo_q(low_flag), .hi_q(high_flag)
  );
endmodule

// File: rtl/adc_wd_chk.sv
module adc_wd_chk
  import adc_wd_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_PAIRS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 res_ready,
  input logic                 s1_valid,
  input logic                 s1_en,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [DATA_W-1:0]    wr_data,
  input logic [NUM_CH-1:0]    oor_status,
  input logic [NUM_PAIRS-1:0] low_flag,
  input logic [NUM_PAIRS-1:0] high_flag
);
  a_r9_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> res_ready);

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1_valid && !wr_en) |=>
      ($stable(oor_status) && $stable(low_flag) && $stable(high_flag)));

  a_r4_disabled_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_en && !wr_en) |=>
      ($stable(oor_status) && $stable(low_flag) && $stable(high_flag)));

  a_r7_one_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> ($countones((low_flag & ~$past(low_flag)) |
                             (high_flag & ~$past(high_flag))) <= 1));

  a_r6_one_new_channel: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> ($countones(oor_status & ~$past(oor_status)) <= 1));

  a_r8_clear_oor: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR_OOR && !s1_valid) |=>
      ((oor_status & $past(wr_data[NUM_CH-1:0])) == '0));
endmodule

bind adc_limit_monitor adc_wd_chk #(.NUM_CH(NUM_CH), .NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_ready(res_ready), .s1_valid(s1_valid),
  .s1_en(s1_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .oor_status(oor_status), .low_flag(low_flag), .high_flag(high_flag)
);

// File: tb/test_adc_limit_monitor.sv
`timescale 1ns/1ps
module test_adc_limit_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [2:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  oor_status;
  logic [15:0] low_flag, high_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  adc_limit_monitor i_adc_limit_monitor (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .oor_status(oor_status), .low_flag(low_flag),
    .high_flag(high_flag)
  );

  // {chan, result, expected oor, expected low flags, expected high flags}
  localparam int NV = 16;
  localparam logic [54:0] VEC [NV] = '{
    {3'd0, 12'd150,  8'h00, 16'h0000, 16'h0000},
    {3'd0, 12'd100,  8'h00, 16'h0000, 16'h0000},
    {3'd0, 12'd200,  8'h00, 16'h0000, 16'h0000},
    {3'd0, 12'd99,   8'h01, 16'h0001, 16'h0000},
    {3'd0, 12'd201,  8'h01, 16'h0000, 16'h0001},
    {3'd3, 12'd50,   8'h08, 16'h0001, 16'h0000},
    {3'd1, 12'd3001, 8'h02, 16'h0000, 16'h0008},
    {3'd1, 12'd999,  8'h02, 16'h0008, 16'h0000},
    {3'd2, 12'd1999, 8'h04, 16'h0020, 16'h0000},
    {3'd2, 12'd2000, 8'h04, 16'h0000, 16'h0020},
    {3'd2, 12'd700,  8'h04, 16'h0020, 16'h0000},
    {3'd2, 12'd4095, 8'h04, 16'h0000, 16'h0020},
    {3'd4, 12'd0,    8'h00, 16'h0000, 16'h0000},
    {3'd4, 12'd4095, 8'h00, 16'h0000, 16'h0000},
    {3'd5, 12'd0,    8'h00, 16'h0000, 16'h0000},
    {3'd7, 12'd4000, 8'h80, 16'h0000, 16'h0008}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_pair(input int k, input int lo, input int hi);
    wr(6'(k), {4'h0, 12'(hi), 4'h0, 12'(lo)});
  endtask

  // returns after the compare edge, on a falling edge
  task automatic send(input logic [2:0] c, input logic [11:0] r);
    @(negedge clk);
    res_valid = 1'b1; res_chan = c; res_data = r;
    @(negedge clk);
    res_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr(6'h21, 32'hFFFF_FFFF);
    wr(6'h22, 32'hFFFF_FFFF);
    wr(6'h23, 32'hFFFF_FFFF);
  endtask

  task automatic setup();
    set_pair(0, 100, 200);
    set_pair(3, 1000, 3000);
    set_pair(5, 2000, 500);
    set_pair(15, 0, 4095);
    wr(6'h10, 32'd0);
    wr(6'h11, 32'd3);
    wr(6'h12, 32'd5);
    wr(6'h13, 32'd0);
    wr(6'h14, 32'd15);
    wr(6'h15, 32'd0);
    wr(6'h17, 32'd3);
    wr(6'h20, 32'h0000_009F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset oor", 32'(oor_status), 32'h0);
    chk("R1 reset low", 32'(low_flag), 32'h0);
    chk("R1 reset high", 32'(high_flag), 32'h0);
    chk("R1 reset ready", 32'(res_ready), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 ready after reset", 32'(res_ready), 32'h1);

    // R4: enable mask resets to zero, so nothing is flagged yet
    send(3'd0, 12'd99);
    chk("R4 reset enable mask", 32'(oor_status), 32'h0);

    setup();

    // vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][54:52], VEC[i][51:40]);
      chk($sformatf("R5 R6 R7 vec%0d oor", i), 32'(oor_status), 32'(VEC[i][39:32]));
      chk($sformatf("R6 R7 vec%0d low", i), 32'(low_flag), 32'(VEC[i][31:16]));
      chk($sformatf("R6 R7 vec%0d high", i), 32'(high_flag), 32'(VEC[i][15:0]));
      clear_all();
    end

    // R3: selector rewrite steers channel 0 to the full-range pair
    wr(6'h10, 32'd15);
    send(3'd0, 12'd99);
    chk("R3 selector rewrite", 32'(oor_status), 32'h0);
    wr(6'h10, 32'd0);
    send(3'd0, 12'd99);
    chk("R3 selector restored", 32'(low_flag), 32'h0001);
    clear_all();

    // R4: a disabled channel keeps its sticky status
    send(3'd1, 12'd999);
    wr(6'h20, 32'h0000_009D);
    send(3'd1, 12'd3001);
    chk("R4 disabled oor kept", 32'(oor_status), 32'h02);
    chk("R4 disabled low kept", 32'(low_flag), 32'h0008);
    chk("R4 disabled no high", 32'(high_flag), 32'h0000);
    wr(6'h20, 32'h0000_009F);
    clear_all();

    // R8: selective write-one-to-clear
    send(3'd0, 12'd99);
    send(3'd1, 12'd3001);
    chk("R8 before clear oor", 32'(oor_status), 32'h03);
    wr(6'h21, 32'h0000_0001);
    chk("R8 partial clear oor", 32'(oor_status), 32'h02);
    chk("R8 low untouched", 32'(low_flag), 32'h0001);
    wr(6'h23, 32'h0000_0008);
    chk("R8 clear high", 32'(high_flag), 32'h0000);
    clear_all();

    // R8: set wins over clear on the same edge
    send(3'd1, 12'd999);
    @(negedge clk);
    res_valid = 1'b1; res_chan = 3'd0; res_data = 12'd99;
    @(negedge clk);
    res_valid = 1'b0;
    wr_en = 1'b1; wr_addr = 6'h22; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 set beats clear", 32'(low_flag), 32'h0001);
    clear_all();

    // R9: latency and back-to-back results
    @(negedge clk);
    res_valid = 1'b1; res_chan = 3'd0; res_data = 12'd99;
    @(negedge clk);
    res_chan = 3'd1; res_data = 12'd3001;
    chk("R9 not yet updated", 32'(oor_status), 32'h00);
    @(negedge clk);
    res_valid = 1'b0;
    chk("R9 first result one edge later", 32'(oor_status), 32'h01);
    @(negedge clk);
    chk("R9 second back-to-back", 32'(oor_status), 32'h03);
    chk("R9 second flag", 32'(high_flag), 32'h0008);

    // R1: reset in mid-run clears sticky state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset oor", 32'(oor_status), 32'h0);
    chk("R1 mid-run reset flags", 32'(low_flag | high_flag), 32'h0);
    chk("R1 mid-run reset ready", 32'(res_ready), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(6'h20, 32'h0000_0001);
    send(3'd0, 12'd4000);
    chk("R1 pair reset to full range", 32'(oor_status), 32'h0);

    report();
  end
endmodule